// File: doc/BRIEF.md
# Converter Serial Result Readout Port

This block is the slave side of a converter's serial output. An internal filter hands it a signed result word with a one-cycle strobe. The block clamps the result into a 20-bit output code, holds it, and signals a ready flag. In bipolar mode the code is offset binary. In unipolar mode it is straight binary.

A host reads the word by pulling chip select low and toggling its own serial clock. The block launches a new bit on each falling serial-clock edge, most significant bit first. It floats the data line when the word is done, and also when the host deselects in the middle of a word.

Chip select and the serial clock are both asynchronous to the master clock. Each is brought in through a flop synchroniser. The master clock must run at least four times faster than the serial clock.

After each accepted result, the block runs a short update window. During that window the ready flag is inactive and a chip-select assertion is not recognised. Once a read has started, the held word cannot change until the read ends.

Top module: `conv_sdo_port`

## Requirements
- R1: After reset, `drdy_n` is 1 and `sdata_oe` is 0. `sdata` reads 0 whenever `sdata_oe` is 0, and `sdata_oe` = 0 means the line is high impedance.
- R2: In bipolar mode (`bipolar` = 1), an in-range result v, with -524288 ≤ v ≤ 524287, is output as the 20-bit value v + 524288 (offset binary).
- R3: In unipolar mode (`bipolar` = 0), an in-range result v, with 0 ≤ v ≤ 1048575, is output unchanged.
- R4: A result above the top of the range is output as 20'hFFFFF. A result below the bottom of the range is output as 20'h00000. The bottom is -524288 in bipolar mode and 0 in unipolar mode.
- R5: A strobe accepted while no read is in progress drives `drdy_n` high for exactly UPD_CYC (4) master cycles after the strobe edge. `drdy_n` is low from then on.
- R6: With `drdy_n` low and no read in progress, `sdata_oe` is 1 and `sdata` carries bit 19 within 4 master cycles after `cs_n` falls.
- R7: Each falling `sclk` edge launches the next lower bit. Bits 19 down to 0 are sent in order, and each bit stays stable between falling edges.
- R8: The 20th falling `sclk` edge of a read floats the line. `drdy_n` then goes high, and a further `cs_n` assertion sends nothing until a new result is accepted.
- R9: If `cs_n` rises before 20 bits are sent, the line keeps driving the current bit until the next falling `sclk` edge and then floats. `drdy_n` stays low, and the next read restarts from bit 19 with the same word.
- R10: A `cs_n` low pulse that lies entirely inside the update window is ignored: no bit is driven and the word remains ready.
- R11: A strobe that arrives while a read is in progress is dropped, and this includes the cycle in which the read starts. The read returns the previously held word, and `drdy_n` is high after that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bipolar | input | 1 | 1 selects offset-binary bipolar coding, 0 selects unipolar |
| res_valid | input | 1 | One-cycle strobe marking a new filter result |
| res_data | input | 22 | Signed two's-complement filter result |
| cs_n | input | 1 | Asynchronous active-low chip select from the host |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdata | output | 1 | Serial data bit (0 while floated) |
| sdata_oe | output | 1 | Output enable for the data pad; 0 is high impedance |
| drdy_n | output | 1 | Active-low word-ready flag |

## Verification
The two functions that can fall in the same master cycle are the acceptance of a new filter result and the start of a read by the synchronised chip select.

The bench lowers `cs_n` on a falling master edge. It then raises `res_valid` exactly two master cycles later, so that the strobe is sampled on the very edge that registers the read start.

The check passes only if the read returns the previously held word rather than the new one. After the read, `drdy_n` must stay high, which shows that the clashing result was dropped rather than latched under the shifter.

// File: rtl/sdo_pkg.sv
// Package: shared types for the serial readout port.
// Assumes: nothing beyond SystemVerilog 2017.
package sdo_pkg;

    // Read engine states.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/sdo_sync.sv
// Module: sdo_sync
// Multi-bit flop synchroniser; each bit is independent.
// Assumes: inputs are quasi-static with respect to clk (levels, not pulses
// shorter than a clock period); RST_VAL gives the idle level of each bit.
module sdo_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sdo_capture.sv
// Module: sdo_capture
// Clamps the filter result into an output code, holds it, and runs the
// update window that keeps the ready flag inactive after each new word.
// Assumes: IN_W > WORD_W; UPD_CYC >= 1; rd_busy covers the read start cycle.
module sdo_capture #(
    parameter int WORD_W  = 20,
    parameter int IN_W    = 22,
    parameter int UPD_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bipolar,
    input  logic                     res_valid,
    input  logic signed [IN_W-1:0]   res_data,
    input  logic                     rd_busy,
    input  logic                     rd_done,
    output logic [WORD_W-1:0]        hold_word,
    output logic                     word_avail
);

    localparam int CNT_W = $clog2(UPD_CYC + 1);
    localparam logic signed [IN_W-1:0] BIP_HI = IN_W'((1 << (WORD_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] BIP_LO = -BIP_HI - IN_W'(1);
    localparam logic signed [IN_W-1:0] UNI_HI = IN_W'((1 << WORD_W) - 1);
    localparam logic signed [IN_W-1:0] ZERO   = '0;

    logic [WORD_W-1:0] sat_word;
    logic [CNT_W-1:0]  win_q;
    logic              accept;

    // Clamp and code the incoming result for the selected range.
    always_comb begin
        if (bipolar) begin
            if (res_data > BIP_HI)      sat_word = '1;
            else if (res_data < BIP_LO) sat_word = '0;
            else sat_word = {~res_data[WORD_W-1], res_data[WORD_W-2:0]};
        end else begin
            if (res_data > UNI_HI)      sat_word = '1;
            else if (res_data < ZERO)   sat_word = '0;
            else sat_word = res_data[WORD_W-1:0];
        end
    end

    assign accept = res_valid && !rd_busy;

    // Hold register, update window counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word  <= '0;
            win_q      <= '0;
            word_avail <= 1'b0;
        end else if (accept) begin
            hold_word  <= sat_word;
            win_q      <= CNT_W'(UPD_CYC);
            word_avail <= 1'b0;
        end else if (win_q != '0) begin
            win_q <= win_q - CNT_W'(1);
            if (win_q == CNT_W'(1)) word_avail <= 1'b1;
        end else if (rd_done) begin
            word_avail <= 1'b0;
        end
    end

    // R11: the held word never changes while a read owns it.
    a_r11_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> $stable(hold_word));

    // R5: an accepted strobe withdraws the ready flag on the next cycle.
    a_r5_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !rd_busy) |=> !word_avail);

endmodule

// File: rtl/sdo_reader.sv
// Module: sdo_reader
// Read engine: starts a read on synchronised chip select, shifts the held
// word out MSB first on detected serial-clock falls, floats the line at the
// end of the word or after a deselect once the current bit completes.
// Assumes: cs_s and sclk_s are already synchronised to clk, and clk runs at
// least four times faster than the serial clock.
module sdo_reader
    import sdo_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              word_avail,
    input  logic [WORD_W-1:0] hold_word,
    output logic              rd_start,
    output logic              rd_busy,
    output logic              rd_done,
    output logic              sdata,
    output logic              sdata_oe
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    rd_state_e         state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              oe_q;
    logic              stop_pend_q;
    logic              sclk_prev_q;
    logic              sclk_fall;

    assign sclk_fall = sclk_prev_q && !sclk_s;
    assign rd_start  = (state_q == RD_IDLE) && !cs_s && word_avail;
    assign rd_busy   = rd_start || (state_q == RD_SHIFT);
    assign sdata     = oe_q & shreg_q[WORD_W-1];
    assign sdata_oe  = oe_q;

    // Serial clock history for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    // Read sequencing, shifting and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RD_IDLE;
            shreg_q     <= '0;
            bit_idx_q   <= '0;
            oe_q        <= 1'b0;
            stop_pend_q <= 1'b0;
            rd_done     <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (rd_start) begin
                        state_q     <= RD_SHIFT;
                        shreg_q     <= hold_word;
                        bit_idx_q   <= '0;
                        oe_q        <= 1'b1;
                        stop_pend_q <= 1'b0;
                    end
                end
                RD_SHIFT: begin
                    if (cs_s) stop_pend_q <= 1'b1;
                    if (sclk_fall) begin
                        if (bit_idx_q == LAST_IDX) begin
                            oe_q    <= 1'b0;
                            state_q <= RD_DONE;
                            rd_done <= 1'b1;
                        end else if (stop_pend_q || cs_s) begin
                            oe_q    <= 1'b0;
                            state_q <= RD_IDLE;
                        end else begin
                            shreg_q   <= {shreg_q[WORD_W-2:0], 1'b0};
                            bit_idx_q <= bit_idx_q + IDX_W'(1);
                        end
                    end
                end
                RD_DONE: begin
                    if (cs_s) state_q <= RD_IDLE;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // R7: a driven bit only changes after a detected serial-clock fall.
    a_r7_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(sclk_fall)) |-> $stable(sdata));

    // R6: a read opens with the MSB of the held word on the line.
    a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (sdata_oe && (sdata == $past(hold_word[WORD_W-1]))));

    // R10: the line is only enabled when a word was ready.
    a_r10_no_start_unready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(word_avail));

    // R9: after deselect the line keeps driving until a serial-clock fall.
    a_r9_finish_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && cs_s && !sclk_fall) |=> sdata_oe);

    // R8: completion of a word leaves the line floated.
    a_r8_float_end: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !sdata_oe);

endmodule

// File: rtl/conv_sdo_port.sv
// Module: conv_sdo_port (top)
// Serial result readout port of a converter: synchronises the host chip
// select and serial clock, clamps and holds filter results, and shifts them
// out on the host clock with a tri-state enable and an active-low ready flag.
// Assumes: clk at least 4x the serial clock; the host waits 4 master cycles
// after lowering cs_n before the first rising serial-clock edge.
module conv_sdo_port #(
    parameter int WORD_W  = 20,
    parameter int IN_W    = 22,
    parameter int UPD_CYC = 4,
    parameter int SYNC_ST = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bipolar,
    input  logic                   res_valid,
    input  logic signed [IN_W-1:0] res_data,
    input  logic                   cs_n,
    input  logic                   sclk,
    output logic                   sdata,
    output logic                   sdata_oe,
    output logic                   drdy_n
);

    logic [1:0]        sync_out;
    logic              cs_s;
    logic              sclk_s;
    logic [WORD_W-1:0] hold_word;
    logic              word_avail;
    logic              rd_start;
    logic              rd_busy;
    logic              rd_done;

    sdo_sync #(
        .W       (2),
        .STAGES  (SYNC_ST),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk}),
        .dout  (sync_out)
    );

    assign cs_s   = sync_out[1];
    assign sclk_s = sync_out[0];

    sdo_capture #(
        .WORD_W  (WORD_W),
        .IN_W    (IN_W),
        .UPD_CYC (UPD_CYC)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .bipolar    (bipolar),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .rd_busy    (rd_busy),
        .rd_done    (rd_done),
        .hold_word  (hold_word),
        .word_avail (word_avail)
    );

    sdo_reader #(
        .WORD_W (WORD_W)
    ) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sclk_s     (sclk_s),
        .word_avail (word_avail),
        .hold_word  (hold_word),
        .rd_start   (rd_start),
        .rd_busy    (rd_busy),
        .rd_done    (rd_done),
        .sdata      (sdata),
        .sdata_oe   (sdata_oe)
    );

    assign drdy_n = ~word_avail;

    // R1: a floated line never shows a 1.
    a_r1_float_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);

    // R8: the ready flag is active throughout any driven bit.
    a_r8_ready_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> !drdy_n);

endmodule

// File: tb/conv_sdo_port_tb.sv
module conv_sdo_port_tb;

    localparam int CLK_P = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bipolar = 1'b1;
    logic               res_valid = 1'b0;
    logic signed [21:0] res_data = '0;
    logic               cs_n = 1'b1;
    logic               sclk = 1'b0;
    logic               sdata;
    logic               sdata_oe;
    logic               drdy_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    conv_sdo_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bipolar   (bipolar),
        .res_valid (res_valid),
        .res_data  (res_data),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdata     (sdata),
        .sdata_oe  (sdata_oe),
        .drdy_n    (drdy_n)
    );

    // Expected output code from the requirements (R2, R3, R4).
    function automatic logic [19:0] exp_word(input logic bip, input int v);
        if (bip) begin
            if (v > 524287)       return 20'hFFFFF;
            else if (v < -524288) return 20'h00000;
            else                  return 20'(v + 524288);
        end else begin
            if (v > 1048575)      return 20'hFFFFF;
            else if (v < 0)       return 20'h00000;
            else                  return 20'(v);
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Present one result; checks the update window (R5) when asked.
    task automatic strobe(input logic bip, input int v, input bit chk_win);
        bipolar   = bip;
        res_data  = 22'(v);
        res_valid = 1'b1;
        cyc(1);
        res_valid = 1'b0;
        if (chk_win) begin
            chk(drdy_n == 1'b1, "R5 window start", drdy_n, 1);
            cyc(3);
            chk(drdy_n == 1'b1, "R5 window end", drdy_n, 1);
            cyc(1);
            chk(drdy_n == 1'b0, "R5 ready after window", drdy_n, 0);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40 && drdy_n; i++) cyc(1);
    endtask

    // Read nbits; if clash, strobe clash_v on the read-start edge (R11).
    task automatic read_word(input int nbits, input bit clash, input int clash_v,
                             output logic [19:0] got);
        got  = '0;
        cs_n = 1'b0;
        cyc(2);
        if (clash) begin
            res_data  = 22'(clash_v);
            res_valid = 1'b1;
        end
        cyc(1);
        res_valid = 1'b0;
        cyc(1);
        chk(sdata_oe == 1'b1, "R6 enable latency", sdata_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            got[19-i] = sdata;
            sclk = 1'b1;
            cyc(4);
            sclk = 1'b0;
            cyc(4);
        end
    endtask

    task automatic full_read(input logic [19:0] exp, input string req);
        logic [19:0] got;
        read_word(20, 1'b0, 0, got);
        chk(got == exp, req, got, exp);
        chk(sdata_oe == 1'b0, "R8 float after last bit", sdata_oe, 0);
        cs_n = 1'b1;
        cyc(4);
        chk(drdy_n == 1'b1, "R8 ready cleared", drdy_n, 1);
    endtask

    initial begin
        cyc(CLK_P * 15000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [19:0] got;
        void'($urandom(32'd7305));
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk(drdy_n == 1'b1, "R1 reset drdy_n", drdy_n, 1);
        chk(sdata_oe == 1'b0, "R1 reset oe", sdata_oe, 0);
        chk(sdata == 1'b0, "R1 reset sdata", sdata, 0);

        // Directed coding and clamp corners.
        strobe(1'b1, 0, 1'b1);        full_read(20'h80000, "R2 bipolar zero");
        strobe(1'b1, -1, 1'b0);       wait_ready(); full_read(20'h7FFFF, "R2 bipolar -1");
        strobe(1'b1, 524287, 1'b0);   wait_ready(); full_read(20'hFFFFF, "R2 bipolar max");
        strobe(1'b1, 524288, 1'b0);   wait_ready(); full_read(20'hFFFFF, "R4 bipolar over");
        strobe(1'b1, -524288, 1'b0);  wait_ready(); full_read(20'h00000, "R2 bipolar min");
        strobe(1'b1, -524289, 1'b0);  wait_ready(); full_read(20'h00000, "R4 bipolar under");
        strobe(1'b0, 1048575, 1'b0);  wait_ready(); full_read(20'hFFFFF, "R3 unipolar max");
        strobe(1'b0, 1048576, 1'b0);  wait_ready(); full_read(20'hFFFFF, "R4 unipolar over");
        strobe(1'b0, -1, 1'b0);       wait_ready(); full_read(20'h00000, "R4 unipolar under");
        strobe(1'b0, 355555, 1'b0);   wait_ready(); full_read(20'h56CE3, "R3 unipolar mid");

        // R8: no second read of a consumed word.
        cs_n = 1'b0;
        cyc(8);
        chk(sdata_oe == 1'b0, "R8 no re-read", sdata_oe, 0);
        cs_n = 1'b1;
        cyc(4);

        // R10: chip-select pulse inside the update window is ignored.
        bipolar = 1'b1;
        res_data = 22'(12345);
        res_valid = 1'b1;
        cyc(1);
        res_valid = 1'b0;
        cs_n = 1'b0;
        cyc(1);
        cs_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (sdata_oe) chk(1'b0, "R10 cs in window drove line", 1, 0);
            cyc(1);
        end
        chk(sdata_oe == 1'b0 && drdy_n == 1'b0, "R10 word still ready",
            {sdata_oe, drdy_n}, 0);

        // R9: deselect mid-word, bit completes, word retained.
        read_word(5, 1'b0, 0, got);
        chk(got[19:15] == exp_word(1'b1, 12345) >> 15, "R7 first five bits",
            got[19:15], exp_word(1'b1, 12345) >> 15);
        cs_n = 1'b1;
        cyc(6);
        chk(sdata_oe == 1'b1, "R9 still driving", sdata_oe, 1);
        chk(sdata == exp_word(1'b1, 12345)[14], "R9 current bit held",
            sdata, exp_word(1'b1, 12345)[14]);
        sclk = 1'b1;
        cyc(4);
        sclk = 1'b0;
        cyc(4);
        chk(sdata_oe == 1'b0, "R9 float after bit", sdata_oe, 0);
        chk(drdy_n == 1'b0, "R9 ready kept", drdy_n, 0);
        full_read(exp_word(1'b1, 12345), "R9 restart from bit 19");

        // R11: strobe on the read-start edge is dropped.
        strobe(1'b1, 1000, 1'b0);
        wait_ready();
        read_word(20, 1'b1, 200000, got);
        chk(got == exp_word(1'b1, 1000), "R11 clash old word", got, exp_word(1'b1, 1000));
        cs_n = 1'b1;
        cyc(20);
        chk(drdy_n == 1'b1, "R11 clash word dropped", drdy_n, 1);

        // Constrained random results across both modes (R2, R3, R4, R7).
        for (int k = 0; k < 30; k++) begin
            logic bip;
            int   v;
            int   sel;
            bip = 1'($urandom_range(0, 1));
            sel = int'($urandom_range(0, 3));
            if (bip) begin
                case (sel)
                    0:       v = 524288 + int'($urandom_range(0, 5000));
                    1:       v = -524289 - int'($urandom_range(0, 5000));
                    default: v = int'($urandom_range(0, 1048575)) - 524288;
                endcase
            end else begin
                case (sel)
                    0:       v = 1048576 + int'($urandom_range(0, 5000));
                    1:       v = -1 - int'($urandom_range(0, 5000));
                    default: v = int'($urandom_range(0, 1048575));
                endcase
            end
            strobe(bip, v, 1'b0);
            wait_ready();
            full_read(exp_word(bip, v), "R7 random word");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule